// File: doc/BRIEF.md
# TDM Serial Receive Deframer

This block takes a time-division-multiplexed serial stream made of a bit clock, a data line and a frame marker. It cuts each frame into a fixed number of equal-width channel slots and gathers the bits of every slot into a parallel word. When a slot is complete and its channel is enabled, the block presents a one-cycle write of that word to a local buffer, addressed by the slot's channel number. Disabled slots are still counted, so the slots after them stay aligned, but nothing is written for them.

The serial lines pass through a two-stage synchronizer into the core clock domain. The bit clock edge that samples the data, the active level of the frame marker and the order in which bits fill a word are runtime inputs. The per-channel enable mask and the bit order are captured when a frame starts, so a configuration change never splits a slot.

Top module: `tdm_rx_deframer`

## Requirements
- R1: After reset `wr_en`, `wr_chan` and `wr_data` are zero, and no write occurs until the first frame marker has been sampled.
- R2: With `cfg_fall_edge` = 0 data is sampled on rising edges of `ser_clk`; with 1 on falling edges. Only the selected edge moves the bit count.
- R3: The frame marker counts as asserted when `ser_sync` is high with `cfg_sync_low` = 0, or low with `cfg_sync_low` = 1.
- R4: A sample edge with the frame marker asserted is bit 0 of channel 0. The bit and channel counts restart there even in the middle of a slot, and the interrupted slot is never written.
- R5: With `cfg_lsb_first` = 0 the first bit of a slot lands in `wr_data` bit SLOT_W-1 and the last in bit 0.
- R6: With `cfg_lsb_first` = 1 the first bit of a slot lands in `wr_data` bit 0 and the last in bit SLOT_W-1. The bit order is captured at the start of each frame.
- R7: A completed slot of channel k gives a write with `wr_chan` = k only if bit k of the captured mask is 1. Slot k is the k-th group of SLOT_W bits after the marker.
- R8: `cfg_chan_en` is captured on each frame marker. A change during a frame takes effect only from the next frame.
- R9: `wr_en` is a single-cycle pulse. It goes high three core clock cycles after the `ser_clk` edge that carries the last bit of the slot (two synchronizer stages plus the output register).
- R10: Bits that arrive after the last slot of a frame and before the next marker are ignored and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data line |
| ser_sync | input | 1 | Frame marker line |
| cfg_fall_edge | input | 1 | 1: sample on falling bit clock edge |
| cfg_sync_low | input | 1 | 1: frame marker is active low |
| cfg_lsb_first | input | 1 | 1: first bit of a slot is word bit 0 |
| cfg_chan_en | input | NCH | Per-channel enable mask |
| wr_en | output | 1 | Buffer write strobe |
| wr_chan | output | CH_W | Buffer index (channel number) |
| wr_data | output | SLOT_W | Assembled slot word |

## Verification
The assertions assume that the bit clock is much slower than the core clock. Sample events must be at least two core cycles apart, and `cfg_fall_edge` may change only while `ser_clk` is idle. This is what keeps writes from running into each other and keeps the captured mask steady when a write comes out. The stimulus holds every bit-clock phase for two core cycles and changes data and marker only on the non-sampling edge. It changes configuration only between frames, with the bit clock parked at the non-sampling level, and only the mask changes in the middle of a frame.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  // Word position of the idx-th bit of a slot of width w
  function automatic int unsigned bit_slot_pos(int unsigned idx, bit_order_e ord, int unsigned w);
    return (ord == ORDER_LSB) ? idx : (w - 1 - idx);
  endfunction

endpackage

// File: rtl/tdm_rx_sampler.sv
module tdm_rx_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_sync,
  input  logic cfg_fall_edge,
  input  logic cfg_sync_low,
  output logic samp_evt,
  output logic samp_bit,
  output logic samp_sync
);
  logic s1_clk, s1_dat, s1_syn;
  logic s2_clk, s2_dat, s2_syn;
  logic s3_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_clk <= 1'b0; s1_dat <= 1'b0; s1_syn <= 1'b0;
      s2_clk <= 1'b0; s2_dat <= 1'b0; s2_syn <= 1'b0;
      s3_clk <= 1'b0;
    end else begin
      s1_clk <= ser_clk;  s1_dat <= ser_data; s1_syn <= ser_sync;
      s2_clk <= s1_clk;   s2_dat <= s1_dat;   s2_syn <= s1_syn;
      s3_clk <= s2_clk;
    end
  end

  logic edge_rise, edge_fall;
  assign edge_rise = s2_clk & ~s3_clk;
  assign edge_fall = ~s2_clk & s3_clk;
  assign samp_evt  = cfg_fall_edge ? edge_fall : edge_rise;
  assign samp_bit  = s2_dat;
  assign samp_sync = s2_syn ^ cfg_sync_low;
endmodule

// File: rtl/tdm_rx_slot_ctl.sv
module tdm_rx_slot_ctl
  import tdm_rx_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int SLOT_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BIT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_evt,
  input  logic             samp_sync,
  input  logic [NCH-1:0]   cfg_chan_en,
  input  logic             cfg_lsb_first,
  output logic             frame_start,
  output logic             bit_adv,
  output logic             slot_done,
  output logic             in_frame,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [BIT_W-1:0] bit_idx,
  output logic [CH_W-1:0]  chan_cnt,
  output logic [NCH-1:0]   mask_q,
  output bit_order_e       order_eff
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_W - 1);
  localparam logic [CH_W-1:0]  LAST_CHAN = CH_W'(NCH - 1);

  bit_order_e order_q;

  assign frame_start = samp_evt & samp_sync;
  assign bit_adv     = samp_evt & ~samp_sync & in_frame;
  assign slot_done   = bit_adv & (bit_cnt == LAST_BIT);
  assign bit_idx     = frame_start ? '0 : bit_cnt;
  assign order_eff   = frame_start ? bit_order_e'(cfg_lsb_first) : order_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      chan_cnt <= '0;
      in_frame <= 1'b0;
      mask_q   <= '0;
      order_q  <= ORDER_MSB;
    end else if (frame_start) begin
      bit_cnt  <= BIT_W'(1);
      chan_cnt <= '0;
      in_frame <= 1'b1;
      mask_q   <= cfg_chan_en;
      order_q  <= bit_order_e'(cfg_lsb_first);
    end else if (bit_adv) begin
      if (bit_cnt == LAST_BIT) begin
        bit_cnt <= '0;
        if (chan_cnt == LAST_CHAN) begin
          chan_cnt <= '0;
          in_frame <= 1'b0;
        end else begin
          chan_cnt <= chan_cnt + CH_W'(1);
        end
      end else begin
        bit_cnt <= bit_cnt + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tdm_rx_packer.sv
module tdm_rx_packer
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 8,
  localparam int BIT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pack_en,
  input  logic              samp_bit,
  input  logic [BIT_W-1:0]  bit_idx,
  input  bit_order_e        order,
  output logic [SLOT_W-1:0] word_nxt
);
  logic [SLOT_W-1:0] word_q;
  logic [BIT_W-1:0]  pos;

  always_comb begin
    pos      = BIT_W'(bit_slot_pos(int'(bit_idx), order, SLOT_W));
    word_nxt = word_q;
    word_nxt[pos] = samp_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (pack_en) word_q <= word_nxt;
  end
endmodule

// File: rtl/tdm_rx_deframer.sv
module tdm_rx_deframer
  import tdm_rx_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int SLOT_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BIT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_sync,
  input  logic              cfg_fall_edge,
  input  logic              cfg_sync_low,
  input  logic              cfg_lsb_first,
  input  logic [NCH-1:0]    cfg_chan_en,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_chan,
  output logic [SLOT_W-1:0] wr_data
);
  logic samp_evt, samp_bit, samp_sync;
  logic frame_start, bit_adv, slot_done, in_frame;
  logic [BIT_W-1:0]  bit_cnt, bit_idx;
  logic [CH_W-1:0]   chan_cnt;
  logic [NCH-1:0]    mask_q;
  bit_order_e        order_eff;
  logic [SLOT_W-1:0] word_nxt;

  tdm_rx_sampler u_samp (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_sync(ser_sync),
    .cfg_fall_edge(cfg_fall_edge), .cfg_sync_low(cfg_sync_low),
    .samp_evt(samp_evt), .samp_bit(samp_bit), .samp_sync(samp_sync)
  );

  tdm_rx_slot_ctl #(.NCH(NCH), .SLOT_W(SLOT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .samp_evt(samp_evt), .samp_sync(samp_sync),
    .cfg_chan_en(cfg_chan_en), .cfg_lsb_first(cfg_lsb_first),
    .frame_start(frame_start), .bit_adv(bit_adv), .slot_done(slot_done),
    .in_frame(in_frame), .bit_cnt(bit_cnt), .bit_idx(bit_idx),
    .chan_cnt(chan_cnt), .mask_q(mask_q), .order_eff(order_eff)
  );

  tdm_rx_packer #(.SLOT_W(SLOT_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .pack_en(frame_start | bit_adv), .samp_bit(samp_bit),
    .bit_idx(bit_idx), .order(order_eff), .word_nxt(word_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_chan <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= slot_done & mask_q[chan_cnt];
      if (slot_done) begin
        wr_chan <= chan_cnt;
        wr_data <= word_nxt;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deframer_chk.sv
module tdm_rx_deframer_chk #(
  parameter int NCH    = 32,
  parameter int SLOT_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BIT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CH_W-1:0]  wr_chan,
  input logic             slot_done,
  input logic             frame_start,
  input logic             in_frame,
  input logic [BIT_W-1:0] bit_cnt,
  input logic [CH_W-1:0]  chan_cnt,
  input logic [NCH-1:0]   mask_q
);
  // R9
  wr_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(slot_done));
  // R9
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7
  wr_active_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mask_q[wr_chan]);
  // R4
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_cnt == BIT_W'(1) && chan_cnt == '0 && in_frame));
  // R10
  idle_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> !slot_done);
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mask_q));
endmodule

bind tdm_rx_deframer tdm_rx_deframer_chk #(.NCH(NCH), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
  .slot_done(slot_done), .frame_start(frame_start), .in_frame(in_frame),
  .bit_cnt(bit_cnt), .chan_cnt(chan_cnt), .mask_q(mask_q)
);

// File: tb/test_tdm_rx_deframer.sv
module test_tdm_rx_deframer;
  localparam int NCH = 4;
  localparam int SW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_sync = 1'b0;
  logic cfg_fall_edge = 1'b0, cfg_sync_low = 1'b0, cfg_lsb_first = 1'b0;
  logic [NCH-1:0] cfg_chan_en = '1;
  logic wr_en;
  logic [1:0] wr_chan;
  logic [SW-1:0] wr_data;

  int total = 0, bad = 0, cyc = 0, last_samp_cyc = 0;
  int exp_ch [0:511];
  int exp_dat[0:511];
  string exp_tag[0:511];
  int head = 0, tail = 0;
  bit done = 0;

  tdm_rx_deframer #(.NCH(NCH), .SLOT_W(SW)) i_tdm_rx_deframer (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_sync(ser_sync), .cfg_fall_edge(cfg_fall_edge), .cfg_sync_low(cfg_sync_low),
    .cfg_lsb_first(cfg_lsb_first), .cfg_chan_en(cfg_chan_en),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write monitor: order, channel, data and latency (R9)
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (head == tail) begin
        check(1'b0, "R7 R10 unexpected write chan", int'(wr_chan), -1);
      end else begin
        check(int'(wr_chan) == exp_ch[head], {exp_tag[head], " R7 chan"}, int'(wr_chan), exp_ch[head]);
        check(int'(wr_data) == exp_dat[head], {exp_tag[head], " data"}, int'(wr_data), exp_dat[head]);
        check(cyc - last_samp_cyc == 3, "R9 latency", cyc - last_samp_cyc, 3);
        head++;
      end
    end
  end

  function automatic int slot_val(int seed, int ch);
    return (seed * 53 + ch * 29 + 7) & 8'hff;
  endfunction

  task automatic push(int ch, int val, string tag);
    exp_ch[tail] = ch; exp_dat[tail] = val; exp_tag[tail] = tag; tail++;
  endtask

  task automatic send_bit(bit b, bit mark);
    @(negedge clk);
    ser_clk  = cfg_fall_edge;
    ser_data = b;
    ser_sync = mark ^ cfg_sync_low;
    repeat (2) @(negedge clk);
    ser_clk = ~cfg_fall_edge;
    last_samp_cyc = cyc;
    @(negedge clk);
  endtask

  task automatic send_word(int val, bit mark);
    for (int k = 0; k < SW; k++) begin
      int pos = cfg_lsb_first ? k : (SW - 1 - k);
      send_bit(val[pos], mark && k == 0);
    end
  endtask

  task automatic send_frame(int seed, logic [NCH-1:0] mask, string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      if (mask[ch]) push(ch, slot_val(seed, ch), tag);
      send_word(slot_val(seed, ch), ch == 0);
    end
  endtask

  task automatic set_cfg(bit fe, bit sl, bit lf);
    @(negedge clk);
    cfg_fall_edge = fe; cfg_sync_low = sl; cfg_lsb_first = lf;
    ser_sync = sl;
    ser_clk  = fe;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain_check(string tag);
    repeat (8) @(negedge clk);
    check(head == tail, {tag, " pending writes"}, tail - head, 0);
  endtask

  initial begin
    logic [NCH-1:0] masks [0:3];
    masks[0] = 4'b1111; masks[1] = 4'b1010; masks[2] = 4'b0101; masks[3] = 4'b0000;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(wr_en == 1'b0, "R1 wr_en reset", int'(wr_en), 0);
    check(wr_chan == '0, "R1 wr_chan reset", int'(wr_chan), 0);
    check(wr_data == '0, "R1 wr_data reset", int'(wr_data), 0);
    rst_n = 1'b1;
    // R1: no writes before the first marker
    for (int k = 0; k < 20; k++) send_bit(k[0], 1'b0);
    drain_check("R1");

    // R2 R3 R5 R6 R7: sweep all configurations and several masks
    for (int c = 0; c < 8; c++) begin
      string tg;
      set_cfg(c[2], c[1], c[0]);
      tg = $sformatf("R2 R3 %s cfg=%0d", c[0] ? "R6" : "R5", c);
      for (int f = 0; f < 2; f++) begin
        logic [NCH-1:0] m = masks[(c + f) % 4];
        if (c == 0 && f == 1) m = 4'b1111;
        cfg_chan_en = m;
        send_frame(c * 4 + f, m, tg);
      end
      drain_check(tg);
    end

    // R8: mask change mid-frame is deferred to next frame
    set_cfg(1'b0, 1'b0, 1'b0);
    cfg_chan_en = 4'b1111;
    for (int ch = 0; ch < NCH; ch++) begin
      push(ch, slot_val(40, ch), "R8 old mask");
      if (ch == 1) begin
        send_word(slot_val(40, ch), 1'b0);
        cfg_chan_en = 4'b0001;
      end else begin
        send_word(slot_val(40, ch), ch == 0);
      end
    end
    send_frame(41, 4'b0001, "R8 new mask");
    drain_check("R8");

    // R10: trailing bits after the last slot are ignored
    cfg_chan_en = 4'b1111;
    send_frame(50, 4'b1111, "R10 frame");
    for (int k = 0; k < 24; k++) send_bit(k[1], 1'b0);
    drain_check("R10");

    // R4: marker in mid-slot restarts; partial slot dropped
    set_cfg(1'b1, 1'b1, 1'b1);
    push(0, slot_val(60, 0), "R4 first slot");
    send_word(slot_val(60, 0), 1'b1);
    for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0);
    send_frame(61, 4'b1111, "R4 restarted frame");
    drain_check("R4");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule